// File: doc/BRIEF.md
# Buffered Block-Program Engine for a NOR-Style Flash

This block is the command and status sequencer of a small parallel flash array that programs data one block at a time through a staging buffer. A host issues byte-wide commands and data over a simple write/read port. Each access carries an address, a 32-bit data word, a width code and a per-access byte-order flag. A block program sequence has four steps. The host sends the start command, then a word count, then the data words, then a confirm command. The data lands in a shadow copy of the addressed block, which is loaded from the array when the count is accepted. The array itself changes only when the confirm command arrives with no error pending.

If the confirm step receives any other byte, the staged data is discarded and the array is left as it was. Accesses that fall outside the staged block, and data writes made while the device is write-protected, set a sticky program-error flag and store nothing. An error pending at the confirm step turns that step into a discard. The commit copies one byte per clock. While it runs, a busy flag is high and the ready bit of the status byte is low.

Top module: `fbw_engine`

## Requirements
- R1: After reset the status byte is 0x80 (bit 7 = ready set, bit 4 = program error clear), busy is low, and every array byte reads as 0xFF.
- R2: In the idle stage, a write whose data bits 7:0 equal 0xE8 starts a sequence. The next write is the word count c, masked to the access width (low 8 bits for width code 0, low 16 bits for code 1, all 32 bits otherwise). Exactly c+1 data writes follow, and the write after them is taken as the confirm byte.
- R3: When the count is accepted, the buffer base becomes the count write's address rounded down to a multiple of the block size, and the buffer is loaded from that block of the array. Buffer bytes that no data write touches keep their old array values through a commit.
- R4: An in-window data write places its bytes in the buffer at offset (address − base). The array, and reads of it, are unchanged until a commit.
- R5: A data write whose address lies below the base, or whose last byte lies past base + block size − 1, sets status bit 4 and stores nothing. An access that ends exactly on the last byte of the block is accepted.
- R6: A data write made while read_only is high sets status bit 4 and stores nothing.
- R7: A confirm byte of 0xD0 with bit 4 clear raises busy for exactly block-size cycles. Status bit 7 is low during that time. Afterwards the array holds the buffer contents, bit 7 is set and the engine is idle.
- R8: A confirm byte other than 0xD0, or 0xD0 while bit 4 is set, discards the buffer, leaves the array unchanged and returns the engine to idle with busy low. Bit 4 keeps its value.
- R9: Bus writes while busy is high have no effect.
- R10: In the idle stage, a write of 0x50 clears status bit 4.
- R11: Width codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. In little-endian order the byte at address a+k is data bits 8k+7:8k. In big-endian order the byte at address a is the most significant byte of the access. Read data sits in the low bytes with the upper bytes zero, and is valid with rd_valid one cycle after the read request. Byte addresses wrap at the array size.
- R12: In the idle stage, write bytes other than 0xE8 and 0x50 (for example 0xD0) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Array read request |
| bus_addr | input | AW | Byte address (AW = BLK_LOG2 + NBLK_LOG2) |
| bus_wdata | input | 32 | Command byte, count or data word |
| bus_width | input | 2 | Access width code |
| bus_big | input | 1 | 1 = big-endian byte order for this access |
| read_only | input | 1 | Write protection for data writes |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| status | output | 8 | Bit 7 ready, bit 4 program error, others zero |
| busy | output | 1 | High while a commit copies the buffer |

## Verification
Assertions check a fixed set of relations on every cycle. Ready is low whenever busy is high. An accepted confirm leads into busy in the next cycle. A rejected confirm leads back to idle. Out-of-window and write-protected data writes raise the error bit, the buffer never takes a write flagged as outside its window, and the status leaving reset is 0x80. The bench scenarios are needed for the rest: masked counts, preservation of preloaded bytes, both byte orders, the array staying unchanged during staging and after discards, writes dropped while busy, and the exact commit length. Only end-to-end reads of the array can show these.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    localparam logic [7:0] CMD_BLOCK_PROG = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_CLEAR_ERR  = 8'h50;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_COUNT,
        PH_DATA,
        PH_CONFIRM,
        PH_COMMIT
    } phase_e;

    // Four byte lanes in address order: lane k belongs to address a+k.
    typedef logic [3:0][7:0] lanes_t;

    typedef struct packed {
        logic [1:0] width;
        logic       big;
    } acc_fmt_t;

    function automatic logic [2:0] fmt_bytes(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic lanes_t split_word(input logic [31:0] v, input acc_fmt_t f);
        lanes_t     l;
        logic [2:0] n;
        logic [1:0] j;
        n = fmt_bytes(f.width);
        l = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(n)) begin
                j = 2'(int'(n) - 1 - k);
                if (f.big) l[k] = v[{j, 3'b000} +: 8];
                else       l[k] = v[8*k +: 8];
            end
        end
        return l;
    endfunction

    function automatic logic [31:0] join_word(input lanes_t l, input acc_fmt_t f);
        logic [31:0] v;
        logic [2:0]  n;
        logic [1:0]  j;
        n = fmt_bytes(f.width);
        v = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(n)) begin
                j = 2'(int'(n) - 1 - k);
                if (f.big) v[{j, 3'b000} +: 8] = l[k];
                else       v[8*k +: 8]         = l[k];
            end
        end
        return v;
    endfunction

    function automatic logic [31:0] mask_count(input logic [31:0] v, input logic [1:0] w);
        case (w)
            2'd0:    return {24'd0, v[7:0]};
            2'd1:    return {16'd0, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/fbw_store.sv
module fbw_store
    import fbw_pkg::*;
#(
    parameter int BLK_LOG2  = 4,
    parameter int NBLK_LOG2 = 3,
    localparam int AW       = BLK_LOG2 + NBLK_LOG2,
    localparam int DEPTH    = 1 << AW,
    localparam int BLK      = 1 << BLK_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [7:0]          wbyte,
    input  logic [AW-1:0]       blk_base,
    output logic [BLK-1:0][7:0] blk_bytes,
    input  logic                rd_en,
    input  logic [AW-1:0]       raddr,
    input  acc_fmt_t            rfmt,
    output logic [31:0]         rdata,
    output logic                rvalid
);

    logic [7:0] mem [DEPTH];
    lanes_t     rlanes;

    // Array contents: reset models an erased array, commit writes one byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wbyte;
        end
    end

    // Whole-block snapshot used to preload the shadow buffer.
    always_comb begin
        for (int i = 0; i < BLK; i++) blk_bytes[i] = mem[blk_base | AW'(i)];
    end

    always_comb begin
        for (int k = 0; k < 4; k++) rlanes[k] = mem[raddr + AW'(k)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= join_word(rlanes, rfmt);
        end
    end

endmodule

// File: rtl/fbw_shadow.sv
module fbw_shadow
    import fbw_pkg::*;
#(
    parameter int BLK_LOG2  = 4,
    parameter int NBLK_LOG2 = 3,
    localparam int AW       = BLK_LOG2 + NBLK_LOG2,
    localparam int BLK      = 1 << BLK_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [AW-1:0]       load_base,
    input  logic [BLK-1:0][7:0] load_bytes,
    input  logic                wr,
    input  logic [AW-1:0]       waddr,
    input  lanes_t              wlanes,
    input  logic [2:0]          wn,
    output logic                oob,
    output logic [AW-1:0]       base,
    input  logic [BLK_LOG2-1:0] rd_idx,
    output logic [7:0]          rd_byte
);

    logic [BLK-1:0][7:0] bufr;
    logic [AW:0]         acc_end;
    logic [AW:0]         win_end;
    logic [BLK_LOG2-1:0] off;

    // Window check with one extra bit so the top block cannot wrap.
    always_comb begin
        acc_end = {1'b0, waddr} + (AW+1)'(wn);
        win_end = {1'b0, base} + (AW+1)'(BLK);
        oob     = (waddr < base) || (acc_end > win_end);
        off     = BLK_LOG2'(waddr - base);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bufr <= '0;
            base <= '0;
        end else if (load) begin
            bufr <= load_bytes;
            base <= load_base;
        end else if (wr) begin
            for (int k = 0; k < 4; k++) begin
                if (k < int'(wn)) bufr[off + BLK_LOG2'(k)] <= wlanes[k];
            end
        end
    end

    assign rd_byte = bufr[rd_idx];

    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        wr |-> !oob) else $error("buffer write outside window"); // R5

endmodule

// File: rtl/fbw_ctrl.sv
module fbw_ctrl
    import fbw_pkg::*;
#(
    parameter int BLK_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [31:0]         wdata,
    input  logic [1:0]          width,
    input  logic                read_only,
    input  logic                oob,
    output logic                buf_load,
    output logic                buf_wr,
    output logic                commit_we,
    output logic [BLK_LOG2-1:0] commit_idx,
    output logic [7:0]          status,
    output logic                busy
);

    phase_e      ph;
    logic [31:0] cnt;
    logic        ready;
    logic        perr;
    logic        accept;
    logic [7:0]  cmd;

    assign cmd    = wdata[7:0];
    assign accept = wr_en && (ph != PH_COMMIT);

    always_comb begin
        buf_load  = accept && (ph == PH_COUNT);
        buf_wr    = accept && (ph == PH_DATA) && !read_only && !oob;
        commit_we = (ph == PH_COMMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            cnt        <= '0;
            ready      <= 1'b1;
            perr       <= 1'b0;
            commit_idx <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        if (cmd == CMD_BLOCK_PROG) begin
                            ph    <= PH_COUNT;
                            ready <= 1'b1;
                        end else if (cmd == CMD_CLEAR_ERR) begin
                            perr <= 1'b0;
                        end
                    end
                end
                PH_COUNT: begin
                    if (accept) begin
                        cnt <= mask_count(wdata, width);
                        ph  <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (accept) begin
                        if (read_only || oob) perr <= 1'b1;
                        ready <= 1'b1;
                        cnt   <= cnt - 32'd1;
                        if (cnt == 32'd0) ph <= PH_CONFIRM;
                    end
                end
                PH_CONFIRM: begin
                    if (accept) begin
                        if ((cmd == CMD_CONFIRM) && !perr) begin
                            ph         <= PH_COMMIT;
                            commit_idx <= '0;
                            ready      <= 1'b0;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end
                end
                PH_COMMIT: begin
                    commit_idx <= commit_idx + 1'b1;
                    if (commit_idx == {BLK_LOG2{1'b1}}) begin
                        ph    <= PH_IDLE;
                        ready <= 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign status = {ready, 2'b00, perr, 4'b0000};
    assign busy   = (ph == PH_COMMIT);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == 8'h80) && !busy) else $error("bad reset state"); // R1
    AST_BUSY_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !status[7]) else $error("ready during commit"); // R7
    AST_CONFIRM_STARTS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_CONFIRM && accept && cmd == CMD_CONFIRM && !status[4])
        |=> busy && !status[7]) else $error("confirm did not commit"); // R7
    AST_DISCARD_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_CONFIRM && accept && !(cmd == CMD_CONFIRM && !status[4]))
        |=> (ph == PH_IDLE) && !busy) else $error("discard did not idle"); // R8
    AST_OOB_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DATA && accept && oob) |=> status[4]) else $error("window error lost"); // R5
    AST_RO_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DATA && accept && read_only) |=> status[4]) else $error("protect error lost"); // R6

endmodule

// File: rtl/fbw_engine.sv
module fbw_engine
    import fbw_pkg::*;
#(
    parameter int BLK_LOG2  = 4,
    parameter int NBLK_LOG2 = 3,
    localparam int AW       = BLK_LOG2 + NBLK_LOG2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic [1:0]    bus_width,
    input  logic          bus_big,
    input  logic          read_only,
    output logic [31:0]   bus_rdata,
    output logic          bus_rvalid,
    output logic [7:0]    status,
    output logic          busy
);

    localparam int BLK = 1 << BLK_LOG2;

    acc_fmt_t            fmt;
    lanes_t              wlanes;
    logic [2:0]          wn;
    logic [AW-1:0]       blk_sel;
    logic [BLK-1:0][7:0] snap;
    logic                oob;
    logic [AW-1:0]       sh_base;
    logic                buf_load;
    logic                buf_wr;
    logic                commit_we;
    logic [BLK_LOG2-1:0] commit_idx;
    logic [7:0]          commit_byte;
    logic [AW-1:0]       commit_addr;

    assign fmt         = {bus_width, bus_big};
    assign wlanes      = split_word(bus_wdata, fmt);
    assign wn          = fmt_bytes(bus_width);
    assign blk_sel     = bus_addr & ~AW'(BLK - 1);
    assign commit_addr = sh_base | AW'(commit_idx);

    fbw_ctrl #(.BLK_LOG2(BLK_LOG2)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr),
        .wdata      (bus_wdata),
        .width      (bus_width),
        .read_only  (read_only),
        .oob        (oob),
        .buf_load   (buf_load),
        .buf_wr     (buf_wr),
        .commit_we  (commit_we),
        .commit_idx (commit_idx),
        .status     (status),
        .busy       (busy)
    );

    fbw_shadow #(.BLK_LOG2(BLK_LOG2), .NBLK_LOG2(NBLK_LOG2)) shadow_i (
        .clk        (clk),
        .rst        (rst),
        .load       (buf_load),
        .load_base  (blk_sel),
        .load_bytes (snap),
        .wr         (buf_wr),
        .waddr      (bus_addr),
        .wlanes     (wlanes),
        .wn         (wn),
        .oob        (oob),
        .base       (sh_base),
        .rd_idx     (commit_idx),
        .rd_byte    (commit_byte)
    );

    fbw_store #(.BLK_LOG2(BLK_LOG2), .NBLK_LOG2(NBLK_LOG2)) store_i (
        .clk       (clk),
        .rst       (rst),
        .we        (commit_we),
        .waddr     (commit_addr),
        .wbyte     (commit_byte),
        .blk_base  (blk_sel),
        .blk_bytes (snap),
        .rd_en     (bus_rd),
        .raddr     (bus_addr),
        .rfmt      (fmt),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

endmodule

// File: tb/fbw_engine_tb_top.sv
module fbw_engine_tb_top;

    localparam int BLK_LOG2  = 4;
    localparam int NBLK_LOG2 = 3;
    localparam int AW        = BLK_LOG2 + NBLK_LOG2;
    localparam int DEPTH     = 1 << AW;
    localparam int BLK       = 1 << BLK_LOG2;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr, bus_rd, bus_big, read_only;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [1:0]    bus_width;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [7:0]    status;
    logic          busy;

    always #4ns clk = ~clk;

    fbw_engine #(.BLK_LOG2(BLK_LOG2), .NBLK_LOG2(NBLK_LOG2)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_width(bus_width), .bus_big(bus_big),
        .read_only(read_only), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .status(status), .busy(busy)
    );

    int          n_checks = 0;
    int          n_errs   = 0;
    logic [7:0]  model [DEPTH];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] mon_exp;
    string       mon_tag;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input int w);
        return (w == 0) ? 1 : (w == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] model_read(input int a, input int w, input bit big);
        int          n = nbytes(w);
        logic [31:0] v = '0;
        for (int k = 0; k < n; k++) begin
            if (big) v[8*(n-1-k) +: 8] = model[(a+k) % DEPTH];
            else     v[8*k +: 8]       = model[(a+k) % DEPTH];
        end
        return v;
    endfunction

    function automatic void model_store(input int a, input logic [31:0] d, input int w, input bit big);
        int n = nbytes(w);
        for (int k = 0; k < n; k++) begin
            if (big) model[(a+k) % DEPTH] = d[8*(n-1-k) +: 8];
            else     model[(a+k) % DEPTH] = d[8*k +: 8];
        end
    endfunction

    task automatic bus_write(input int a, input logic [31:0] d, input int w, input bit big);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_width = 2'(w);
        bus_big   = big;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver side of the scoreboard: expected read data goes into the queue.
    task automatic bus_read(input int a, input int w, input bit big, input string req);
        exp_q.push_back(model_read(a, w, big));
        tag_q.push_back(req);
        @(negedge clk);
        bus_rd    = 1'b1;
        bus_addr  = AW'(a);
        bus_width = 2'(w);
        bus_big   = big;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor side: pops an expected item per returned read.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errs++;
                $display("FAIL R11: actual=%h expected=no read data", bus_rdata);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                check(mon_tag, bus_rdata, mon_exp);
            end
        end
    end

    task automatic run_commit(input string req);
        int c;
        bus_write(0, 32'h0000_00D0, 0, 1'b0);
        check({req, " busy after confirm"}, 32'(busy), 32'd1);
        check({req, " ready low in commit"}, 32'(status), 32'h00);
        c = 1;
        forever begin
            @(negedge clk);
            if (!busy) break;
            c++;
        end
        check({req, " commit length"}, c, BLK);
        check({req, " ready after commit"}, 32'(status), 32'h80);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int c;
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_big = 1'b0; read_only = 1'b0;
        bus_addr = '0; bus_wdata = '0; bus_width = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 status", 32'(status), 32'h80);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 rvalid", 32'(bus_rvalid), 32'd0);
        bus_read(0, 2, 1'b0, "R1 erased read");

        // R2 R4 R11: count 0xFFFF0003 with width 1 -> masked to 3 -> four data writes
        bus_write(20, 32'h0000_00E8, 0, 1'b0);
        bus_write(20, 32'hFFFF_0003, 1, 1'b0);
        bus_write(16, 32'h1122_3344, 2, 1'b0);
        bus_write(20, 32'hA1B2_C3D4, 2, 1'b1);
        bus_write(24, 32'h0000_BEEF, 1, 1'b0);
        bus_write(29, 32'h0000_005A, 0, 1'b0);
        check("R2 status in confirm stage", 32'(status), 32'h80);
        bus_read(16, 2, 1'b0, "R4 array unchanged before commit");
        run_commit("R7");
        model_store(16, 32'h1122_3344, 2, 1'b0);
        model_store(20, 32'hA1B2_C3D4, 2, 1'b1);
        model_store(24, 32'h0000_BEEF, 1, 1'b0);
        model_store(29, 32'h0000_005A, 0, 1'b0);
        bus_read(16, 2, 1'b0, "R11 little-endian word");
        bus_read(20, 2, 1'b0, "R11 big-endian write read back little");
        bus_read(24, 2, 1'b1, "R11 big-endian read");
        bus_read(28, 2, 1'b0, "R3 untouched bytes kept");
        bus_read(29, 0, 1'b0, "R11 byte read");
        bus_read(22, 1, 1'b1, "R11 halfword big-endian read");

        // R3: preload keeps earlier contents of the block
        bus_write(17, 32'h0000_00E8, 0, 1'b0);
        bus_write(17, 32'h0000_0000, 0, 1'b0);
        bus_write(17, 32'h0000_0077, 0, 1'b0);
        run_commit("R3");
        model_store(17, 32'h77, 0, 1'b0);
        bus_read(16, 2, 1'b0, "R3 preload merge");
        bus_read(20, 2, 1'b1, "R3 rest of block kept");

        // R8: abort by a non-confirm byte; R12: 0xD0 in idle does nothing
        bus_write(32, 32'h0000_00E8, 0, 1'b0);
        bus_write(32, 32'h0000_0000, 0, 1'b0);
        bus_write(32, 32'hCAFE_F00D, 2, 1'b0);
        bus_write(32, 32'h0000_00FF, 0, 1'b0);
        check("R8 busy after abort", 32'(busy), 32'd0);
        check("R8 status after abort", 32'(status), 32'h80);
        bus_read(32, 2, 1'b0, "R8 array unchanged by abort");
        bus_write(32, 32'h0000_00D0, 0, 1'b0);
        check("R12 confirm byte in idle", 32'(busy), 32'd0);
        check("R12 status unchanged", 32'(status), 32'h80);

        // R2: count masked to byte width: 0x102 -> 2 -> three data writes
        bus_write(40, 32'h0000_00E8, 0, 1'b0);
        bus_write(40, 32'h0000_0102, 0, 1'b0);
        bus_write(40, 32'h0000_0001, 0, 1'b0);
        bus_write(41, 32'h0000_0002, 0, 1'b0);
        bus_write(42, 32'h0000_0003, 0, 1'b0);
        run_commit("R2");
        model_store(40, 32'h01, 0, 1'b0);
        model_store(41, 32'h02, 0, 1'b0);
        model_store(42, 32'h03, 0, 1'b0);
        bus_read(40, 2, 1'b0, "R2 masked count data");

        // R5: above window, then confirm refused due to pending error
        bus_write(48, 32'h0000_00E8, 0, 1'b0);
        bus_write(48, 32'h0000_0001, 0, 1'b0);
        bus_write(64, 32'h5555_5555, 2, 1'b0);
        check("R5 error above window", 32'(status), 32'h90);
        bus_write(48, 32'h6666_6666, 2, 1'b0);
        bus_write(48, 32'h0000_00D0, 0, 1'b0);
        check("R8 confirm with error refused", 32'(busy), 32'd0);
        check("R8 error bit kept", 32'(status), 32'h90);
        bus_read(48, 2, 1'b0, "R5 array unchanged");
        bus_read(64, 2, 1'b0, "R5 out-of-window data dropped");
        bus_write(0, 32'h0000_0050, 0, 1'b0);
        check("R10 clear error", 32'(status), 32'h80);

        // R5: below base and past the top of the last block
        bus_write(116, 32'h0000_00E8, 0, 1'b0);
        bus_write(116, 32'h0000_0001, 0, 1'b0);
        bus_write(110, 32'h0000_1234, 1, 1'b0);
        check("R5 error below base", 32'(status), 32'h90);
        bus_write(126, 32'h9999_9999, 2, 1'b0);
        bus_write(0, 32'h0000_00FF, 0, 1'b0);
        bus_read(110, 1, 1'b0, "R5 below-base data dropped");
        bus_read(124, 2, 1'b0, "R5 top-block data dropped");
        bus_write(0, 32'h0000_0050, 0, 1'b0);

        // R5: access ending exactly on the last byte of the block is accepted
        bus_write(112, 32'h0000_00E8, 0, 1'b0);
        bus_write(112, 32'h0000_0000, 0, 1'b0);
        bus_write(124, 32'h0102_0304, 2, 1'b1);
        check("R5 exact fit no error", 32'(status), 32'h80);
        run_commit("R5");
        model_store(124, 32'h0102_0304, 2, 1'b1);
        bus_read(124, 2, 1'b1, "R5 exact fit stored");
        bus_read(126, 2, 1'b0, "R11 read wraps at top");

        // R6: write protection
        read_only = 1'b1;
        bus_write(64, 32'h0000_00E8, 0, 1'b0);
        bus_write(64, 32'h0000_0000, 0, 1'b0);
        bus_write(64, 32'h1234_5678, 2, 1'b0);
        check("R6 error when protected", 32'(status), 32'h90);
        read_only = 1'b0;
        bus_write(64, 32'h0000_00D0, 0, 1'b0);
        check("R6 no commit", 32'(busy), 32'd0);
        bus_read(64, 2, 1'b0, "R6 array unchanged");
        bus_write(0, 32'h0000_0050, 0, 1'b0);
        check("R10 clear after protect", 32'(status), 32'h80);

        // R9: a start command during commit is dropped
        bus_write(0, 32'h0000_00E8, 0, 1'b0);
        bus_write(0, 32'h0000_0000, 0, 1'b0);
        bus_write(0, 32'hDEAD_BEEF, 2, 1'b0);
        bus_write(0, 32'h0000_00D0, 0, 1'b0);
        check("R9 commit started", 32'(busy), 32'd1);
        bus_write(64, 32'h0000_00E8, 0, 1'b0);
        c = 0;
        while (busy && c < 100) begin
            @(negedge clk);
            c++;
        end
        model_store(0, 32'hDEAD_BEEF, 2, 1'b0);
        bus_write(64, 32'h0000_0000, 0, 1'b0);
        bus_write(64, 32'h0000_00AB, 0, 1'b0);
        bus_write(64, 32'h0000_00D0, 0, 1'b0);
        check("R9 write during busy ignored", 32'(busy), 32'd0);
        bus_read(0, 2, 1'b0, "R9 commit completed");
        bus_read(64, 0, 1'b0, "R9 no stray program");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_errs++;
            $display("FAIL R11: actual=%0d pending reads expected=0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule